// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two 18-bit tri-state ports, A and B, with one non-inverting data path in each direction. Each path owns a storage word. The storage can follow its input pins while a pass control is high. It freezes when that control drops. With pass low, it loads on a rising edge of the path's own strobe. Each path also has an output enable that releases its destination port to high impedance. The A-to-B enable is active high and the B-to-A enable is active low. A disabled path keeps updating its storage, so a word captured while the port is released appears as soon as the port is enabled.

The design runs on one system clock. The pass and strobe controls are sampled at each rising clock edge. Each direction has a small mode machine with three states. TRACK means pass is high. HOLD_LO means pass is low and the strobe was last seen low. HOLD_HI means pass is low and the strobe was last seen high. Every state moves to TRACK when pass is high. Otherwise it moves to HOLD_HI when the strobe is high and to HOLD_LO when the strobe is low. A load occurs whenever pass is high. In HOLD_LO a load also occurs when the strobe reads high; this is the "strobe edge" transition. While pass is high, the destination port follows the source pins combinationally. Otherwise it shows the stored word.

Top module: `bidir_store_xcvr`

## Requirements
- R1: Both paths are 18 bits wide and non-inverting; every bit lane carries its own value unchanged.
- R2: With pass high and the path enabled, the destination port equals the source port in the same cycle, with no clock edge in between.
- R3: When pass falls, the storage keeps the source value sampled at the last system clock edge at which pass was still high. The destination then holds that word while the source changes.
- R4: A strobe edge is a system clock edge at which pass and strobe read low and high, where pass and strobe read low and low at the edge before. On a strobe edge the storage loads the source pins sampled at that edge. The stored word appears on the destination from that edge on.
- R5: With pass low and the strobe static (high or low) or falling, the storage does not change.
- R6: The A-to-B enable is active high. While it is low, port B is released (high impedance), yet the A-to-B storage still loads by R3 and R4.
- R7: The B-to-A path follows R2 to R5 with its own pass and strobe controls. Its enable is active low (0 drives port A, 1 releases it).
- R8: An active-low asynchronous reset clears both storage words to zero and releases both ports whatever the enables are. At the first edge after reset, the strobe counts as previously high, so no strobe edge can occur there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pass and strobe are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| a2b_en | input | 1 | A-to-B output enable, active high |
| b2a_en_n | input | 1 | B-to-A output enable, active low |
| a2b_pass | input | 1 | A-to-B pass control (1 = follow, 0 = hold/strobe) |
| b2a_pass | input | 1 | B-to-A pass control |
| a2b_strobe | input | 1 | A-to-B load strobe, rising edge captures |
| b2a_strobe | input | 1 | B-to-A load strobe |
| port_a | inout | 18 | A-side data port |
| port_b | inout | 18 | B-side data port |

## Verification
The bench builds the block with its default width of 18, so every bit lane is exercised. The patterns set the lowest and highest bits alone and also use alternating and mixed words. Both ports carry pull-ups in the bench, so a released port reads all ones. The high-impedance checks therefore use stored words that contain zeros. At that width, a word captured while the port is released can be told apart from a released port, and a transparent value can be told apart from a frozen one.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        PM_TRACK   = 2'd0,
        PM_HOLD_LO = 2'd1,
        PM_HOLD_HI = 2'd2
    } path_mode_e;
endpackage

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pass_i,
    input  logic strobe_i,
    output logic load_o
);
    path_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_HOLD_HI;
        else        state_q <= state_d;
    end

    // next state and load decision
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        unique case (state_q)
            PM_TRACK: begin
                load_o = pass_i;
                if (pass_i)        state_d = PM_TRACK;
                else if (strobe_i) state_d = PM_HOLD_HI;
                else               state_d = PM_HOLD_LO;
            end
            PM_HOLD_LO: begin
                load_o = pass_i | strobe_i;
                if (pass_i)        state_d = PM_TRACK;
                else if (strobe_i) state_d = PM_HOLD_HI;
                else               state_d = PM_HOLD_LO;
            end
            PM_HOLD_HI: begin
                load_o = pass_i;
                if (pass_i)        state_d = PM_TRACK;
                else if (strobe_i) state_d = PM_HOLD_HI;
                else               state_d = PM_HOLD_LO;
            end
            default: begin
                state_d = PM_HOLD_HI;
                load_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/xcvr_pad.sv
module xcvr_pad #(
    parameter int W = 18
) (
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    inout  wire  [W-1:0] pad_io
);
    assign pad_io = en_i ? d_i : {W{1'bz}};
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
    parameter int W      = 18,
    parameter bit OE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_i,
    input  logic         pass_i,
    input  logic         strobe_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output logic         drive_o
);
    logic         load;
    logic         oe_act;
    logic [W-1:0] store_q;

    xcvr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pass_i   (pass_i),
        .strobe_i (strobe_i),
        .load_o   (load)
    );

    xcvr_store #(.W(W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .d_i    (din_i),
        .q_o    (store_q)
    );

    generate
        if (OE_LOW) begin : g_oe_low
            assign oe_act = ~oe_i;
        end else begin : g_oe_high
            assign oe_act = oe_i;
        end
    endgenerate

    assign dout_o  = pass_i ? din_i : store_q;
    assign drive_o = rst_n & oe_act;

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R3
    pass_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(pass_i)) |-> (store_q == $past(din_i)));

    // R4
    strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !pass_i && !$past(pass_i) && strobe_i && !$past(strobe_i))
        |=> (store_q == $past(din_i)));

    // R5
    static_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !pass_i && !(strobe_i && !$past(strobe_i) && !$past(pass_i)))
        |=> $stable(store_q));
endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a2b_en,
    input  logic         b2a_en_n,
    input  logic         a2b_pass,
    input  logic         b2a_pass,
    input  logic         a2b_strobe,
    input  logic         b2a_strobe,
    inout  wire  [W-1:0] port_a,
    inout  wire  [W-1:0] port_b
);
    localparam int NDIR = 2;

    logic [NDIR-1:0]      oe_v, pass_v, strobe_v, drive_v;
    logic [NDIR-1:0][W-1:0] din_v, dout_v;

    assign oe_v     = {b2a_en_n, a2b_en};
    assign pass_v   = {b2a_pass, a2b_pass};
    assign strobe_v = {b2a_strobe, a2b_strobe};
    assign din_v[0] = port_a;
    assign din_v[1] = port_b;

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            xcvr_path #(.W(W), .OE_LOW(d == 1)) u_path (
                .clk      (clk),
                .rst_n    (rst_n),
                .oe_i     (oe_v[d]),
                .pass_i   (pass_v[d]),
                .strobe_i (strobe_v[d]),
                .din_i    (din_v[d]),
                .dout_o   (dout_v[d]),
                .drive_o  (drive_v[d])
            );
        end
    endgenerate

    xcvr_pad #(.W(W)) u_pad_b (.en_i(drive_v[0]), .d_i(dout_v[0]), .pad_io(port_b));
    xcvr_pad #(.W(W)) u_pad_a (.en_i(drive_v[1]), .d_i(dout_v[1]), .pad_io(port_a));

    // R6 R7
    no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_v[0] && drive_v[1]));
endmodule

// File: tb/sim_bidir_store_xcvr.sv
module sim_bidir_store_xcvr;
    localparam int W = 18;
    localparam int CLK_PERIOD = 10;
    localparam logic [W-1:0] REL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a2b_en = 1'b1, b2a_en_n = 1'b0;
    logic a2b_pass = 1'b0, b2a_pass = 1'b0;
    logic a2b_strobe = 1'b0, b2a_strobe = 1'b0;
    logic tb_a_en = 1'b0, tb_b_en = 1'b0;
    logic [W-1:0] tb_a = '0, tb_b = '0;
    tri1 [W-1:0] port_a;
    tri1 [W-1:0] port_b;
    assign port_a = tb_a_en ? tb_a : {W{1'bz}};
    assign port_b = tb_b_en ? tb_b : {W{1'bz}};

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R8";

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_store_xcvr #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .a2b_en(a2b_en), .b2a_en_n(b2a_en_n),
        .a2b_pass(a2b_pass), .b2a_pass(b2a_pass),
        .a2b_strobe(a2b_strobe), .b2a_strobe(b2a_strobe),
        .port_a(port_a), .port_b(port_b)
    );

    // reference model: stored words and previous control samples
    logic [W-1:0] m_ab, m_ba;
    logic p_le_ab, p_cp_ab, p_le_ba, p_cp_ba;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ab <= '0; m_ba <= '0;
            p_le_ab <= 1'b0; p_cp_ab <= 1'b1;
            p_le_ba <= 1'b0; p_cp_ba <= 1'b1;
        end else begin
            if (a2b_pass || (!p_le_ab && !p_cp_ab && a2b_strobe)) m_ab <= port_a;
            if (b2a_pass || (!p_le_ba && !p_cp_ba && b2a_strobe)) m_ba <= port_b;
            p_le_ab <= a2b_pass; p_cp_ab <= a2b_strobe;
            p_le_ba <= b2a_pass; p_cp_ba <= b2a_strobe;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [W-1:0] eb, ea;
        eb = (!rst_n || !a2b_en) ? REL : (a2b_pass ? port_a : m_ab);
        ea = (!rst_n || b2a_en_n) ? REL : (b2a_pass ? port_b : m_ba);
        if (!done && !tb_b_en) begin
            checks++;
            if (port_b !== eb) begin
                errors++;
                $display("FAIL %s port_b actual %h expected %h", cur_tag, port_b, eb);
            end
        end
        if (!done && !tb_a_en) begin
            checks++;
            if (port_a !== ea) begin
                errors++;
                $display("FAIL %s port_a actual %h expected %h", cur_tag, port_a, ea);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_b(input logic [W-1:0] v, input string tag);
        @(negedge clk);
        checks++;
        if (port_b !== v) begin
            errors++;
            $display("FAIL %s direct port_b actual %h expected %h", tag, port_b, v);
        end
        #1;
    endtask

    task automatic expect_a(input logic [W-1:0] v, input string tag);
        @(negedge clk);
        checks++;
        if (port_a !== v) begin
            errors++;
            $display("FAIL %s direct port_a actual %h expected %h", tag, port_a, v);
        end
        #1;
    endtask

    initial begin
        // R8: reset releases both ports even with both enables asserted
        cur_tag = "R8";
        step(); step();
        expect_a(REL, "R8");
        a2b_en = 1'b0; b2a_en_n = 1'b1;
        rst_n = 1'b1;
        tb_a_en = 1'b1; tb_a = 18'h2AAAA;
        a2b_strobe = 1'b1;
        step();
        a2b_en = 1'b1;
        expect_b('0, "R8");

        // R1 R2: transparent follow
        cur_tag = "R1 R2";
        a2b_strobe = 1'b0;
        a2b_pass = 1'b1;
        tb_a = 18'h00001; expect_b(18'h00001, "R1");
        tb_a = 18'h20000; expect_b(18'h20000, "R1");
        tb_a = 18'h12345; expect_b(18'h12345, "R2");
        tb_a = 18'h15555; expect_b(18'h15555, "R2");

        // R3: freeze on pass falling
        cur_tag = "R3";
        tb_a = 18'h1357A; step();
        a2b_pass = 1'b0; tb_a = 18'h0F0F0;
        expect_b(18'h1357A, "R3");
        tb_a = 18'h00000; expect_b(18'h1357A, "R3");

        // R4 R5: strobe capture and static hold
        cur_tag = "R4 R5";
        tb_a = 18'h0F0F0; a2b_strobe = 1'b1;
        expect_b(18'h0F0F0, "R4");
        tb_a = 18'h3C3C3; expect_b(18'h0F0F0, "R5");
        a2b_strobe = 1'b0; expect_b(18'h0F0F0, "R5");
        tb_a = 18'h00F0F; expect_b(18'h0F0F0, "R5");
        a2b_strobe = 1'b1; expect_b(18'h00F0F, "R4");

        // R6: disabled port released while storage keeps loading
        cur_tag = "R6";
        a2b_en = 1'b0; a2b_strobe = 1'b0; tb_a = 18'h00000;
        expect_b(REL, "R6");
        a2b_strobe = 1'b1; expect_b(REL, "R6");
        a2b_strobe = 1'b0; tb_a = 18'h3FFFF; step();
        a2b_en = 1'b1; expect_b(18'h00000, "R6");
        a2b_pass = 1'b1; tb_a = 18'h00410; step();
        a2b_en = 1'b0; a2b_pass = 1'b0; tb_a = 18'h3FFFF; expect_b(REL, "R6");
        a2b_en = 1'b1; expect_b(18'h00410, "R6");

        // R7: mirror direction with active-low enable
        cur_tag = "R7";
        a2b_en = 1'b0; tb_a_en = 1'b0; step();
        tb_b_en = 1'b1; tb_b = 18'h2468A; b2a_pass = 1'b1; step();
        b2a_en_n = 1'b0; expect_a(18'h2468A, "R7");
        tb_b = 18'h00003; expect_a(18'h00003, "R7");
        b2a_pass = 1'b0; tb_b = 18'h3FFF0; expect_a(18'h00003, "R7");
        b2a_strobe = 1'b1; expect_a(18'h3FFF0, "R7");
        tb_b = 18'h11111; expect_a(18'h3FFF0, "R7");
        b2a_strobe = 1'b0; tb_b = 18'h00000; step();
        b2a_strobe = 1'b1; b2a_en_n = 1'b1; expect_a(REL, "R7");
        b2a_en_n = 1'b0; expect_a(18'h00000, "R7");

        // R8: reset in mid-operation clears storage
        cur_tag = "R8";
        b2a_en_n = 1'b1; b2a_strobe = 1'b0; tb_b_en = 1'b0;
        rst_n = 1'b0; step();
        rst_n = 1'b1; step();
        a2b_en = 1'b1; expect_b('0, "R8");
        step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule